// File: doc/BRIEF.md
# Banked SPI Register Access Engine

This block is an SPI master that sits between a host and a peripheral whose control registers are split into four banks. The host presents one request at a time: a 3-bit operation code, an 8-bit register address and, for writes, a data byte. The engine frames the command and data bytes, drives chip select and a mode-0 shift clock, and returns the byte read back together with a one-cycle completion pulse.

The address carries three fields. Bits 4:0 give the register index. Bits 6:5 give the bank. Bit 7 marks registers that place one extra dummy byte ahead of their read data. The engine keeps a copy of the bank it last selected. When a request targets a different bank, or the copy is not valid, the engine first runs two short transactions on a common control register to move the peripheral to the new bank. Only then does it run the requested access. A soft-reset request sends a single byte and forgets the cached bank.

Top module: `spi_bank_engine`

## Requirements
- R1: The first byte of every requested transaction is `{op, addr[4:0]}`. The op codes are: 3'b000 read register, 3'b010 write register, 3'b100 bit-field set, 3'b101 bit-field clear, 3'b111 soft reset.
- R2: A read with `addr[7]` clear is the command byte followed by one 0x00 byte. `rdata` takes the byte shifted in during that 0x00 byte.
- R3: A read with `addr[7]` set is the command byte followed by two 0x00 bytes. `rdata` takes the byte shifted in during the last of them.
- R4: Write, bit-field set and bit-field clear are each two bytes: the command byte, then `wdata`.
- R5: If `addr[6:5]` differs from the cached bank, or the cache is invalid, the requested transaction is preceded by two transactions. The first is 0xBF, 0x03, which clears both select bits of control register index 0x1F. The second is 0x9F followed by the bank value in bits 1:0 with zeros above. When the bank matches a valid cache, no bank transaction is sent.
- R6: The bank cache is invalid after reset and after a soft reset. A soft reset is the single byte 0xFF with no bank transaction.
- R7: Each transaction has its own low period on `spi_cs_n`. `spi_cs_n` stays high for at least 2*HALF_DIV clock cycles between transactions. `spi_sck` is low whenever `spi_cs_n` is high.
- R8: SPI mode 0, MSB first. Each `spi_sck` level lasts HALF_DIV clock cycles, and consecutive rising edges within a transaction are 2*HALF_DIV cycles apart.
- R9: `busy` rises only in response to `req`. `done` is a one-cycle pulse after the final transaction of a request. A `req` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, sampled while idle |
| op | input | 3 | Operation code |
| addr | input | 8 | Dummy flag, bank and register index |
| wdata | input | 8 | Data byte for write and bit-field operations |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Shift clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest case to reach is a bank switch forced onto a bank that already matches the cached value. Only an invalidated cache can cause this. The bench issues a soft reset and then accesses the bank that was selected before it. It also uses a soft reset ahead of a bank-0 read, so the clear-then-set pair appears with a zero bank value. A bench-side SPI slave returns a different byte at each position within a transaction. Because of this, returning the data from the wrong byte slot of a normal or extended read gives a visibly wrong `rdata`.

// File: rtl/spi_bank_engine.sv
module spi_bank_engine #(
  parameter int          HALF_DIV = 2,
  parameter logic [4:0]  BANK_REG = 5'h1F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [2:0] op,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [2:0] OP_RD  = 3'b000;
  localparam logic [2:0] OP_BFS = 3'b100;
  localparam logic [2:0] OP_BFC = 3'b101;
  localparam logic [2:0] OP_RST = 3'b111;
  localparam logic [1:0] STG_CLR = 2'd0, STG_SET = 2'd1, STG_MAIN = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP} st_t;

  st_t        st;
  logic [CW-1:0] div_cnt;
  logic [1:0] stage, byte_idx;
  logic [2:0] bit_idx;
  logic       gap_half, bank_ok;
  logic [1:0] bank_q;
  logic [2:0] op_q;
  logic [7:0] addr_q, wdata_q, sr_out, sr_in;

  wire tick = (div_cnt == CW'(HALF_DIV - 1));
  wire need_sw = (op != OP_RST) && (!bank_ok || bank_q != addr[6:5]);
  wire [1:0] last_idx = (stage != STG_MAIN) ? 2'd1 :
                        (op_q == OP_RST) ? 2'd0 :
                        (op_q == OP_RD && addr_q[7]) ? 2'd2 : 2'd1;

  function automatic logic [7:0] byte_val(input logic [1:0] stg, input logic [1:0] idx,
                                          input logic [2:0] o, input logic [7:0] a,
                                          input logic [7:0] d);
    if (idx == 2'd0) begin
      case (stg)
        STG_CLR: byte_val = {OP_BFC, BANK_REG};
        STG_SET: byte_val = {OP_BFS, BANK_REG};
        default: byte_val = (o == OP_RST) ? 8'hFF : {o, a[4:0]};
      endcase
    end else begin
      case (stg)
        STG_CLR: byte_val = 8'h03;
        STG_SET: byte_val = {6'b0, a[6:5]};
        default: byte_val = (o == OP_RD) ? 8'h00 : d;
      endcase
    end
  endfunction

  assign busy     = (st != S_IDLE);
  assign spi_mosi = sr_out[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; stage <= STG_MAIN; byte_idx <= '0; bit_idx <= '0;
      gap_half <= 1'b0; bank_ok <= 1'b0; bank_q <= '0; op_q <= '0; addr_q <= '0;
      wdata_q <= '0; sr_out <= '0; sr_in <= '0; rdata <= '0; done <= 1'b0;
      spi_cs_n <= 1'b1; spi_sck <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_cnt <= (st == S_IDLE || tick) ? '0 : div_cnt + 1'b1;
      case (st)
        S_IDLE: if (req) begin
          op_q <= op; addr_q <= addr; wdata_q <= wdata;
          stage    <= need_sw ? STG_CLR : STG_MAIN;
          byte_idx <= '0; bit_idx <= '0;
          sr_out   <= byte_val(need_sw ? STG_CLR : STG_MAIN, 2'd0, op, addr, wdata);
          bank_ok  <= (op != OP_RST);
          if (op != OP_RST) bank_q <= addr[6:5];
          spi_cs_n <= 1'b0;
          st       <= S_LEAD;
        end
        S_LEAD: if (tick) st <= S_SHIFT;
        S_SHIFT: if (tick) begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            sr_in   <= {sr_in[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              bit_idx <= '0;
              if (byte_idx == last_idx) begin
                if (stage == STG_MAIN && op_q == OP_RD) rdata <= sr_in;
                spi_cs_n <= 1'b1;
                gap_half <= 1'b0;
                st       <= S_GAP;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                sr_out   <= byte_val(stage, byte_idx + 1'b1, op_q, addr_q, wdata_q);
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              sr_out  <= {sr_out[6:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          if (!gap_half) gap_half <= 1'b1;
          else if (stage == STG_MAIN) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            stage    <= stage + 1'b1;
            byte_idx <= '0;
            sr_out   <= byte_val(stage + 1'b1, 2'd0, op_q, addr_q, wdata_q);
            spi_cs_n <= 1'b0;
            st       <= S_LEAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_bank_engine_chk.sv
module spi_bank_engine_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sck
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'hFFFF;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(2 * HALF_DIV)));

  // R8
  sck_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sck) |-> $past(!spi_cs_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
endmodule

bind spi_bank_engine spi_bank_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/tb_spi_bank_engine.sv
module tb_spi_bank_engine;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic busy, done, spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [7:0] rdata;

  always #4 clk = ~clk;

  spi_bank_engine #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, errors = 0;
  int ntx = 0, nb = 0, cur = 0, dn = 0;
  logic [7:0] gbyte [0:255];
  int tx_start [0:63];
  int tx_len [0:63];
  logic [2:0] bitc = '0;
  logic [1:0] pos = '0;
  logic [7:0] shreg = '0;
  logic [7:0] resp [0:3] = '{8'h11, 8'hA5, 8'h3C, 8'h77};

  assign spi_miso = spi_cs_n ? 1'b0 : resp[pos][3'd7 - bitc];

  always @(negedge spi_cs_n) begin
    cur = ntx; ntx = ntx + 1; tx_len[cur] = 0; tx_start[cur] = nb; bitc = '0; pos = '0;
  end
  always @(posedge spi_sck) begin
    shreg = {shreg[6:0], spi_mosi};
    if (bitc == 3'd7) begin
      gbyte[nb] = shreg; nb = nb + 1; tx_len[cur] = tx_len[cur] + 1;
      bitc = '0; pos = pos + 1'b1;
    end else bitc = bitc + 1'b1;
  end

  int hi_run = 1000, min_gap = 1000, since_rise = 0, sck_min = 1000, sck_max = 0;
  logic sck_d = 1'b0, in_frame = 1'b0;
  always @(posedge clk) begin
    if (done) dn = dn + 1;
    if (spi_cs_n) hi_run = hi_run + 1;
    else begin
      if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) in_frame = 1'b0;
      hi_run = 0;
    end
    since_rise = since_rise + 1;
    if (spi_sck && !sck_d) begin
      if (in_frame) begin
        if (since_rise < sck_min) sck_min = since_rise;
        if (since_rise > sck_max) sck_max = since_rise;
      end
      in_frame = 1'b1; since_rise = 0;
    end
    sck_d = spi_sck;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] o, input logic [7:0] a, input logic [7:0] d);
    int t;
    @(negedge clk); op = o; addr = a; wdata = d; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy, "R9 busy after req", busy, 1);
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R9 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic check_tx(input int t, input int len, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2, input string r);
    logic [7:0] e [0:2];
    e[0] = b0; e[1] = b1; e[2] = b2;
    chk(tx_len[t] == len, {r, " length"}, tx_len[t], len);
    for (int i = 0; i < len && i < tx_len[t]; i++)
      chk(gbyte[tx_start[t] + i] == e[i], {r, " byte"}, gbyte[tx_start[t] + i], e[i]);
  endtask

  task automatic t_reset;
    chk(spi_cs_n == 1'b1, "R7 reset cs high", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R7 reset sck low", spi_sck, 0);
    chk(!busy && !done, "R9 reset idle", {busy, done}, 0);
  endtask

  task automatic t_first_read;
    int t0 = ntx;
    run_req(3'b000, 8'h23, 8'h00);
    chk(ntx - t0 == 3, "R5 first access switches bank", ntx - t0, 3);
    check_tx(t0, 2, 8'hBF, 8'h03, 8'h00, "R5 clear");
    check_tx(t0 + 1, 2, 8'h9F, 8'h01, 8'h00, "R5 set bank1");
    check_tx(t0 + 2, 2, 8'h03, 8'h00, 8'h00, "R1 R2 read frame");
    chk(rdata == 8'hA5, "R2 read data", rdata, 8'hA5);
  endtask

  task automatic t_cached_read;
    int t0 = ntx;
    run_req(3'b000, 8'h2A, 8'h00);
    chk(ntx - t0 == 1, "R5 same bank no switch", ntx - t0, 1);
    check_tx(t0, 2, 8'h0A, 8'h00, 8'h00, "R2 cached read");
  endtask

  task automatic t_write;
    int t0 = ntx;
    run_req(3'b010, 8'h44, 8'h5A);
    chk(ntx - t0 == 3, "R5 new bank switch", ntx - t0, 3);
    check_tx(t0 + 1, 2, 8'h9F, 8'h02, 8'h00, "R5 set bank2");
    check_tx(t0 + 2, 2, 8'h44, 8'h5A, 8'h00, "R4 write frame");
    chk(rdata == 8'hA5, "R2 rdata held over write", rdata, 8'hA5);
  endtask

  task automatic t_dummy_read;
    int t0 = ntx;
    run_req(3'b000, 8'hC7, 8'h00);
    chk(ntx - t0 == 1, "R3 cached bank", ntx - t0, 1);
    check_tx(t0, 3, 8'h07, 8'h00, 8'h00, "R3 extended read frame");
    chk(rdata == 8'h3C, "R3 read data from last byte", rdata, 8'h3C);
  endtask

  task automatic t_bitfield;
    int t0 = ntx;
    run_req(3'b100, 8'h5F, 8'h81);
    run_req(3'b101, 8'h41, 8'h0F);
    chk(ntx - t0 == 2, "R4 bit-field count", ntx - t0, 2);
    check_tx(t0, 2, 8'h9F, 8'h81, 8'h00, "R4 set frame");
    check_tx(t0 + 1, 2, 8'hA1, 8'h0F, 8'h00, "R4 clear frame");
  endtask

  task automatic t_soft_reset_same_bank;
    int t0 = ntx;
    run_req(3'b111, 8'h00, 8'h00);
    check_tx(t0, 1, 8'hFF, 8'h00, 8'h00, "R6 soft reset byte");
    run_req(3'b000, 8'h43, 8'h00);
    chk(ntx - t0 == 4, "R6 switch after soft reset", ntx - t0, 4);
    check_tx(t0 + 1, 2, 8'hBF, 8'h03, 8'h00, "R6 clear");
    check_tx(t0 + 2, 2, 8'h9F, 8'h02, 8'h00, "R6 set bank2");
    chk(rdata == 8'hA5, "R2 read after reset", rdata, 8'hA5);
  endtask

  task automatic t_bank0;
    int t0 = ntx;
    run_req(3'b111, 8'h00, 8'h00);
    run_req(3'b000, 8'h05, 8'h00);
    chk(ntx - t0 == 4, "R5 bank0 switch", ntx - t0, 4);
    check_tx(t0 + 2, 2, 8'h9F, 8'h00, 8'h00, "R5 set bank0");
    check_tx(t0 + 3, 2, 8'h05, 8'h00, 8'h00, "R1 bank0 read");
  endtask

  task automatic t_ignore_busy;
    int t0 = ntx, d0 = dn;
    @(negedge clk); op = 3'b000; addr = 8'h2B; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (30) @(negedge clk);
    op = 3'b111; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (400) @(negedge clk);
    chk(ntx - t0 == 3, "R9 busy req ignored", ntx - t0, 3);
    chk(dn - d0 == 1, "R9 one done", dn - d0, 1);
    chk(!busy, "R9 idle after", busy, 0);
    check_tx(t0 + 2, 2, 8'h0B, 8'h00, 8'h00, "R9 original request kept");
  endtask

  task automatic t_timing;
    chk(min_gap >= 2 * HALF, "R7 cs gap", min_gap, 2 * HALF);
    chk(sck_min == 2 * HALF && sck_max == 2 * HALF, "R8 sck period", sck_min, 2 * HALF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_read;
    t_cached_read;
    t_write;
    t_dummy_read;
    t_bitfield;
    t_soft_reset_same_bank;
    t_bank0;
    t_ignore_busy;
    t_timing;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule